// File: doc/BRIEF.md
# Back-Buffer Line Fill Engine

This block fills a run of words in a double-buffered framebuffer with a constant value. Software programs a word count and a start address, then writes the fill value. That last write launches the run. The engine then issues one 16-bit write per clock into whichever buffer is currently hidden from the display. Address steps stay inside a 256-word line: only the low byte of the address advances, so a run that crosses the end of a line wraps back to the start of the same line.

The same block owns the frame-select bit, which names the displayed buffer. A new frame-select value takes effect at once when the display is blanked vertically or the display mode is off. At any other time the value is parked as pending and is applied on the next rising edge of vertical blank. The framebuffer memory sits outside the block, behind a plain write port.

Top module: `fbfill_top`

## Requirements
- R1: After reset, `busy`, `fb_we`, `frame_sel` and `fs_pending` are 0, and `fill_addr`, `fill_word` and `fill_len` are 0.
- R2: A fill writes `fill_len`+1 words, one per clock on consecutive cycles, so a length of 0 writes exactly one word.
- R3: A register write with `reg_sel`=2 (data) while idle starts a fill. Every word of that fill carries the written value on `fb_data`, and the first word appears in the cycle after the write.
- R4: Successive fill words advance `fb_addr` by one in bits [7:0] only. Bits [15:8] stay fixed, so address 0xNNFF is followed by 0xNN00.
- R5: Once the fill ends, `fill_addr` holds the line-wrapped address that follows the last word written, and `fill_word` holds the fill value.
- R6: During a fill, `fb_buf` equals the inverse of `frame_sel`.
- R7: A write with `reg_sel`=3 loads `reg_wdata[0]` into `frame_sel` on the next cycle when `vblank` is 1 or `disp_mode` is 0, and clears any pending value.
- R8: A `reg_sel`=3 write made while `vblank` is 0 and `disp_mode` is non-zero leaves `frame_sel` unchanged and sets `fs_pending`. The stored value moves to `frame_sel` in the cycle after the next rising edge of `vblank`, and `fs_pending` then clears.
- R9: While `busy` is 1, writes to the length (`reg_sel`=0), start (`reg_sel`=1) and data (`reg_sel`=2) registers are ignored. The running fill keeps its value and addresses, and no second fill follows.
- R10: `fb_we` is high exactly while `busy` is high, and `busy` drops in the cycle after the last word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 length, 1 start, 2 data, 3 frame select |
| reg_wdata | input | 16 | Register write value |
| vblank | input | 1 | Vertical blank indicator |
| disp_mode | input | 2 | Display mode field, 0 means display off |
| busy | output | 1 | Fill in progress |
| fill_addr | output | 16 | Current start-address register |
| fill_word | output | 16 | Fill-data register |
| fill_len | output | 8 | Fill-length register (words minus one) |
| frame_sel | output | 1 | Displayed-buffer select |
| fs_pending | output | 1 | A frame-select change is waiting for vertical blank |
| fb_we | output | 1 | Framebuffer write enable |
| fb_buf | output | 1 | Framebuffer bank being written |
| fb_addr | output | 16 | Framebuffer word address |
| fb_data | output | 16 | Framebuffer write data |

## Verification
Fills are run with a mid-line start, with a start two words below a line end, and with a length of zero. These cases separate correct low-byte wrapping from a full-width increment and expose off-by-one counts. A fill that receives extra data and start writes while it runs shows whether those writes leak into the active run. Frame-select writes are made in three conditions: during blank, with the display off, and during active display followed by a blank edge. This separates the immediate path from the deferred one and shows that the fill target follows the inverted select.

// File: rtl/fbfill_pkg.sv
package fbfill_pkg;
   typedef enum logic [1:0] {
      SEL_LEN   = 2'd0,
      SEL_START = 2'd1,
      SEL_DATA  = 2'd2,
      SEL_FSEL  = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/fbfill_run.sv
module fbfill_run #(
   parameter int ADDR_W       = 16,
   parameter int DATA_W       = 16,
   parameter int LEN_W        = 8,
   parameter int LINE_W       = 8,
   parameter bit WRAP_IN_LINE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              len_we,
   input  logic              start_we,
   input  logic              data_we,
   input  logic [DATA_W-1:0] wdata,
   output logic              busy,
   output logic [ADDR_W-1:0] cur_addr,
   output logic [DATA_W-1:0] cur_word,
   output logic [LEN_W-1:0]  len_q
);
   localparam int CNT_W = LEN_W + 1;

   initial begin
      if (ADDR_W > DATA_W) $error("ADDR_W must not exceed DATA_W");
      if (LEN_W > DATA_W)  $error("LEN_W must not exceed DATA_W");
      if (LINE_W >= ADDR_W || LINE_W < 1) $error("LINE_W out of range");
   end

   logic [LEN_W-1:0]  remain_q;
   logic [ADDR_W-1:0] next_addr;

   generate
      if (WRAP_IN_LINE) begin : g_line_wrap
         logic [LINE_W-1:0] low_inc;
         assign low_inc   = cur_addr[LINE_W-1:0] + 1'b1;
         assign next_addr = {cur_addr[ADDR_W-1:LINE_W], low_inc};
      end else begin : g_flat
         assign next_addr = cur_addr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         cur_addr <= '0;
         cur_word <= '0;
         len_q    <= '0;
         remain_q <= '0;
      end else if (busy) begin
         cur_addr <= next_addr;
         remain_q <= remain_q - 1'b1;
         if (remain_q == '0) busy <= 1'b0;
      end else begin
         if (len_we)   len_q    <= wdata[LEN_W-1:0];
         if (start_we) cur_addr <= wdata[ADDR_W-1:0];
         if (data_we) begin
            cur_word <= wdata;
            remain_q <= len_q;
            busy     <= 1'b1;
         end
      end
   end

   // word counter used only by the checks below
   logic [CNT_W-1:0] words_q;
   always_ff @(posedge clk) begin
      if (!rst_n)                words_q <= '0;
      else if (data_we && !busy) words_q <= '0;
      else if (busy)             words_q <= words_q + 1'b1;
   end

   p_len_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> words_q == ({1'b0, len_q} + 1'b1));

   p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && (data_we || start_we || len_we)) |=> $stable(cur_word) && $stable(len_q));

   p_addr_line_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |->
         cur_addr[ADDR_W-1:LINE_W] == $past(cur_addr[ADDR_W-1:LINE_W]));

   p_word_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(cur_word));
endmodule

// File: rtl/fbfill_fsel.sv
module fbfill_fsel (
   input  logic clk,
   input  logic rst_n,
   input  logic fs_we,
   input  logic fs_val,
   input  logic vblank,
   input  logic mode_zero,
   output logic frame_sel,
   output logic pending
);
   logic vb_q;
   logic pend_val;
   logic vb_rise;

   assign vb_rise = vblank && !vb_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vb_q      <= 1'b0;
         frame_sel <= 1'b0;
         pending   <= 1'b0;
         pend_val  <= 1'b0;
      end else begin
         vb_q <= vblank;
         if (fs_we) begin
            if (vblank || mode_zero) begin
               frame_sel <= fs_val;
               pending   <= 1'b0;
            end else begin
               pending  <= 1'b1;
               pend_val <= fs_val;
            end
         end else if (vb_rise && pending) begin
            frame_sel <= pend_val;
            pending   <= 1'b0;
         end
      end
   end

   p_fs_now_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (fs_we && (vblank || mode_zero)) |=> (frame_sel == $past(fs_val)) && !pending);

   p_fs_defer_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (fs_we && !vblank && !mode_zero) |=> $stable(frame_sel) && pending);

   p_fs_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!fs_we && !vb_rise) |=> $stable(frame_sel));
endmodule

// File: rtl/fbfill_top.sv
module fbfill_top
   import fbfill_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 16,
   parameter int LEN_W  = 8,
   parameter int LINE_W = 8,
   parameter int MODE_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [1:0]        reg_sel,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic              vblank,
   input  logic [MODE_W-1:0] disp_mode,
   output logic              busy,
   output logic [ADDR_W-1:0] fill_addr,
   output logic [DATA_W-1:0] fill_word,
   output logic [LEN_W-1:0]  fill_len,
   output logic              frame_sel,
   output logic              fs_pending,
   output logic              fb_we,
   output logic              fb_buf,
   output logic [ADDR_W-1:0] fb_addr,
   output logic [DATA_W-1:0] fb_data
);
   reg_sel_e sel;
   assign sel = reg_sel_e'(reg_sel);

   fbfill_run #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W),
      .LINE_W(LINE_W), .WRAP_IN_LINE(1'b1)
   ) u_run (
      .clk      (clk),
      .rst_n    (rst_n),
      .len_we   (reg_we && sel == SEL_LEN),
      .start_we (reg_we && sel == SEL_START),
      .data_we  (reg_we && sel == SEL_DATA),
      .wdata    (reg_wdata),
      .busy     (busy),
      .cur_addr (fill_addr),
      .cur_word (fill_word),
      .len_q    (fill_len)
   );

   fbfill_fsel u_fsel (
      .clk       (clk),
      .rst_n     (rst_n),
      .fs_we     (reg_we && sel == SEL_FSEL),
      .fs_val    (reg_wdata[0]),
      .vblank    (vblank),
      .mode_zero (disp_mode == '0),
      .frame_sel (frame_sel),
      .pending   (fs_pending)
   );

   assign fb_we   = busy;
   assign fb_buf  = ~frame_sel;
   assign fb_addr = fill_addr;
   assign fb_data = fill_word;

   p_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && sel == SEL_DATA && !busy) |=> fb_we && fb_data == $past(reg_wdata));

   p_back_buf_r6: assert property (@(posedge clk) disable iff (!rst_n)
      fb_we |-> fb_buf != frame_sel);
endmodule

// File: tb/fbfill_top_bench.sv
module fbfill_top_bench;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [1:0]  reg_sel = 2'd0;
   logic [15:0] reg_wdata = 16'h0;
   logic        vblank = 1'b0;
   logic [1:0]  disp_mode = 2'd1;
   logic        busy, frame_sel, fs_pending, fb_we, fb_buf;
   logic [15:0] fill_addr, fill_word, fb_addr, fb_data;
   logic [7:0]  fill_len;

   int total = 0;
   int bad = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   fbfill_top u_fbfill_top (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .vblank(vblank), .disp_mode(disp_mode),
      .busy(busy), .fill_addr(fill_addr), .fill_word(fill_word),
      .fill_len(fill_len), .frame_sel(frame_sel), .fs_pending(fs_pending),
      .fb_we(fb_we), .fb_buf(fb_buf), .fb_addr(fb_addr), .fb_data(fb_data)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // behavioural reference model
   bit       m_busy, m_fs, m_pend, m_pval, m_vbq;
   int       m_cnt, m_len;
   bit [15:0] m_addr, m_word;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_busy = 0; m_fs = 0; m_pend = 0; m_pval = 0; m_vbq = 0;
         m_cnt = 0; m_len = 0; m_addr = 0; m_word = 0;
      end else begin
         if (m_busy) begin
            m_addr = {m_addr[15:8], 8'(m_addr[7:0] + 8'd1)};
            if (m_cnt == 0) m_busy = 0;
            else m_cnt = m_cnt - 1;
         end else if (reg_we) begin
            if (reg_sel == 2'd0) m_len = reg_wdata[7:0];
            if (reg_sel == 2'd1) m_addr = reg_wdata;
            if (reg_sel == 2'd2) begin m_word = reg_wdata; m_cnt = m_len; m_busy = 1; end
         end
         if (reg_we && reg_sel == 2'd3) begin
            if (vblank || disp_mode == 0) begin m_fs = reg_wdata[0]; m_pend = 0; end
            else begin m_pend = 1; m_pval = reg_wdata[0]; end
         end else if (vblank && !m_vbq && m_pend) begin
            m_fs = m_pval; m_pend = 0;
         end
         m_vbq = vblank;
      end
   end

   bit [15:0] log_addr[$];
   bit [15:0] log_data[$];
   bit        log_buf[$];

   always @(negedge clk) begin
      if (rst_n) begin
         check(busy == m_busy, "R10 busy", busy, m_busy);
         check(fb_we == m_busy, "R10 fb_we", fb_we, m_busy);
         check(frame_sel == m_fs, "R8 frame_sel", frame_sel, m_fs);
         check(fs_pending == m_pend, "R8 fs_pending", fs_pending, m_pend);
         check(fill_addr == m_addr, "R5 fill_addr", fill_addr, m_addr);
         check(fill_word == m_word, "R5 fill_word", fill_word, m_word);
         if (m_busy) check(fb_buf == !m_fs, "R6 fb_buf", fb_buf, !m_fs);
      end
      if (fb_we) begin
         log_addr.push_back(fb_addr);
         log_data.push_back(fb_data);
         log_buf.push_back(fb_buf);
      end
   end

   task automatic wr(input logic [1:0] sel, input logic [15:0] val);
      @(negedge clk);
      reg_we = 1'b1; reg_sel = sel; reg_wdata = val;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 400 && busy; i++) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic clear_log();
      log_addr.delete(); log_data.delete(); log_buf.delete();
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      for (int i = 0; i < 20000; i++) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(!busy && !fb_we, "R1 idle", busy, 0);
      check(frame_sel == 0 && fs_pending == 0, "R1 fsel", frame_sel, 0);
      check(fill_addr == 0 && fill_word == 0 && fill_len == 0, "R1 regs", fill_addr, 0);

      // R2 R3 mid-line fill of four words
      clear_log();
      wr(2'd0, 16'd3); wr(2'd1, 16'h1234); wr(2'd2, 16'hABCD);
      wait_idle();
      check(log_addr.size() == 4, "R2 count", log_addr.size(), 4);
      for (int i = 0; i < log_addr.size(); i++) begin
         check(log_addr[i] == 16'h1234 + i, "R4 addr", log_addr[i], 16'h1234 + i);
         check(log_data[i] == 16'hABCD, "R3 data", log_data[i], 16'hABCD);
      end
      check(fill_addr == 16'h1238, "R5 end addr", fill_addr, 16'h1238);
      check(fill_word == 16'hABCD, "R5 end word", fill_word, 16'hABCD);

      // R4 wrap at line end
      clear_log();
      wr(2'd1, 16'h12FE); wr(2'd2, 16'h5A5A);
      wait_idle();
      check(log_addr.size() == 4, "R2 count wrap", log_addr.size(), 4);
      if (log_addr.size() == 4) begin
         check(log_addr[1] == 16'h12FF, "R4 ff", log_addr[1], 16'h12FF);
         check(log_addr[2] == 16'h1200, "R4 wrap", log_addr[2], 16'h1200);
         check(log_addr[3] == 16'h1201, "R4 after", log_addr[3], 16'h1201);
      end
      check(fill_addr == 16'h1202, "R5 wrap end", fill_addr, 16'h1202);

      // R2 zero length writes one word
      clear_log();
      wr(2'd0, 16'd0); wr(2'd1, 16'h0040); wr(2'd2, 16'h0F0F);
      wait_idle();
      check(log_addr.size() == 1, "R2 len0", log_addr.size(), 1);

      // R9 writes while busy ignored
      clear_log();
      wr(2'd0, 16'd7); wr(2'd1, 16'h0500); wr(2'd2, 16'h1111);
      wr(2'd2, 16'h2222); wr(2'd1, 16'h0900); wr(2'd0, 16'd1);
      wait_idle();
      check(log_addr.size() == 8, "R9 count", log_addr.size(), 8);
      for (int i = 0; i < log_addr.size(); i++) begin
         check(log_data[i] == 16'h1111, "R9 data", log_data[i], 16'h1111);
         check(log_addr[i] == 16'h0500 + i, "R9 addr", log_addr[i], 16'h0500 + i);
      end
      check(fill_len == 8'd7, "R9 len", fill_len, 7);

      // R8 deferred frame select, R6 fill target
      disp_mode = 2'd1; vblank = 1'b0;
      wr(2'd3, 16'h0001);
      check(frame_sel == 0 && fs_pending == 1, "R8 deferred", frame_sel, 0);
      clear_log();
      wr(2'd2, 16'h7777);
      wait_idle();
      check(log_buf.size() == 8 && log_buf[0] == 1'b1, "R6 buf1", log_buf.size(), 8);
      @(negedge clk); vblank = 1'b1;
      @(negedge clk);
      check(frame_sel == 1 && fs_pending == 0, "R8 applied", frame_sel, 1);
      clear_log();
      wr(2'd2, 16'h8888);
      wait_idle();
      check(log_buf.size() > 0 && log_buf[0] == 1'b0, "R6 buf0", log_buf.size(), 8);

      // R7 immediate during blank and with display off
      wr(2'd3, 16'h0000);
      check(frame_sel == 0, "R7 vblank", frame_sel, 0);
      vblank = 1'b0; disp_mode = 2'd0;
      wr(2'd3, 16'h0001);
      check(frame_sel == 1 && fs_pending == 0, "R7 mode0", frame_sel, 1);

      repeat (4) @(negedge clk);
      finish_run();
   end
endmodule